// File: doc/BRIEF.md
# Burst Scrambler with Preamble Insertion

This block frames one transmit burst as a serial bit stream for a downstream symbol mapper. It advances one bit per pulse of a bit-rate strobe. When the transmit enable input rises, it first emits a programmable preamble taken from a 96-bit word, without scrambling. It then emits payload bits, each XORed with a pseudo-noise bit from one of two hardwired linear feedback shift registers. The preamble length is clamped up to a minimum set by the modulation mode. The shift register is reloaded with a programmable seed at the start of every burst, so each burst begins the same pseudo-noise sequence.

Control is a three-state machine: `ST_IDLE`, `ST_PREAMBLE` and `ST_PAYLOAD`. It has these transitions:
- `ST_IDLE` to `ST_PREAMBLE` on a rising transmit enable when the effective length is not zero.
- `ST_IDLE` to `ST_PAYLOAD` on a rising transmit enable when the effective length is zero.
- `ST_PREAMBLE` to `ST_PAYLOAD` on the strobe that emits the last preamble bit.
- Any active state to `ST_IDLE` when transmit enable is low.

Every emitted bit is presented with a valid flag and a flag that marks preamble bits.

Top module: `burst_scrambler`

## Requirements
- R1: While reset is asserted and after its release, `dout`, `dout_vld` and `dout_is_pre` are 0 until a burst emits a bit.
- R2: After transmit enable rises, the first E strobes each emit one preamble bit, most significant bit first. Bit k of the burst is `pre_word[95-k]`, with `dout_is_pre`=1. E is the effective length, and a `pre_len` above 96 saturates at 96.
- R3: The effective length is never below the mode floor. `mode` encodings: 0 FSK and 1 QPSK have floor 0, 2 DQPSK has floor 2, 3 16-QAM and 4 differential 16-QAM have floor 4, and codes 5 to 7 have floor 0.
- R4: The first payload bit is emitted on the strobe right after the one carrying the last preamble bit. When E is 0, it is emitted on the first strobe of the burst.
- R5: With `poly_sel`=0, the generator is a 15-stage register S1..S15 loaded with S(i+1)=`seed[i]`. Each payload bit outputs `din` XOR p, where p = S14 XOR S15. The register then shifts S(i+1)<=S(i), with S1<=p.
- R6: With `poly_sel`=1, the same rule applies to a 6-stage register loaded from `seed[5:0]`, with p = S5 XOR S6.
- R7: The seed is reloaded at every rise of transmit enable. A burst that follows a truncated burst restarts the sequence from the seed.
- R8: While transmit enable is low, no bit is emitted, and a strobe has no effect. In the cycle where it rises, no bit is emitted.
- R9: `dout_vld` rises for exactly one cycle per accepted strobe. Its results are registered at the same clock edge that samples the strobe.
- R10: `dout_is_pre` is 1 only together with `dout_vld`, and only for preamble bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Burst enable; a rise starts a burst |
| bit_stb | input | 1 | Bit-rate strobe, one pulse per bit |
| din | input | 1 | Payload bit sampled on the strobe |
| mode | input | 3 | Modulation mode code for the preamble floor |
| poly_sel | input | 1 | 0: 15-stage generator, 1: 6-stage generator |
| seed | input | 15 | Generator seed, reloaded per burst |
| pre_len | input | 7 | Requested preamble length in bits |
| pre_word | input | 96 | Preamble bits, sent MSB first |
| dout | output | 1 | Serial output bit |
| dout_vld | output | 1 | Output bit is valid |
| dout_is_pre | output | 1 | Output bit belongs to the preamble |

## Verification
Each output bit appears at the rising edge that samples its strobe. The bench drives inputs on the falling edge and samples one nanosecond after the next rising edge, then compares. A rise of transmit enable takes one edge to register, and the bench holds the strobe low during that edge and checks that nothing is emitted. Strobe-free cycles are placed between bits, and their outputs are checked to be not valid. The expected preamble bits and pseudo-noise bits come from a bench model that counts the strobes accepted since the rise.

// File: rtl/bscr_pkg.sv
package bscr_pkg;

    localparam int NUM_POLY = 2;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PREAMBLE = 2'd1,
        ST_PAYLOAD  = 2'd2
    } bscr_state_e;

    // Generator length per polynomial index
    function automatic int poly_len(input int idx);
        return (idx == 0) ? 15 : 6;
    endfunction

    // Inner feedback tap per polynomial index
    function automatic int poly_tap(input int idx);
        return (idx == 0) ? 14 : 5;
    endfunction

    // Mode floor on the preamble length, in bits
    function automatic int min_preamble(input logic [2:0] mode_code);
        case (mode_code)
            3'd2:    return 2;
            3'd3:    return 4;
            3'd4:    return 4;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/bscr_len_policy.sv
module bscr_len_policy #(
    parameter int PRE_BITS = 96,
    parameter int LEN_W    = 7
) (
    input  logic [2:0]       mode,
    input  logic [LEN_W-1:0] req_len,
    output logic [LEN_W-1:0] eff_len
);
    import bscr_pkg::*;

    logic [LEN_W-1:0] floor_len;
    logic [LEN_W-1:0] capped_len;

    always_comb begin
        floor_len  = LEN_W'(min_preamble(mode));
        capped_len = (req_len > LEN_W'(PRE_BITS)) ? LEN_W'(PRE_BITS) : req_len;
        eff_len    = (capped_len < floor_len) ? floor_len : capped_len;
    end

endmodule

// File: rtl/bscr_pn_gen.sv
module bscr_pn_gen #(
    parameter int LEN = 15,
    parameter int TAP = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           advance,
    input  logic [LEN-1:0] seed,
    output logic           pn
);
    logic [LEN-1:0] stages;

    assign pn = stages[TAP-1] ^ stages[LEN-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stages <= '1;
        end else if (load) begin
            stages <= seed;
        end else if (advance) begin
            stages <= {stages[LEN-2:0], pn};
        end
    end

endmodule

// File: rtl/bscr_ctrl.sv
module bscr_ctrl #(
    parameter int LEN_W = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_en,
    input  logic                 bit_stb,
    input  logic [LEN_W-1:0]     eff_len,
    output bscr_pkg::bscr_state_e state,
    output logic [LEN_W-1:0]     pre_idx,
    output logic                 load_seed,
    output logic                 advance,
    output logic                 emit
);
    import bscr_pkg::*;

    bscr_state_e      nxt;
    logic             tx_en_q;
    logic             rise;
    logic [LEN_W-1:0] len_q;

    assign rise = tx_en & ~tx_en_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (rise) begin
                    nxt = (eff_len == '0) ? ST_PAYLOAD : ST_PREAMBLE;
                end
            end
            ST_PREAMBLE: begin
                if (!tx_en) begin
                    nxt = ST_IDLE;
                end else if (bit_stb && (pre_idx == len_q - LEN_W'(1))) begin
                    nxt = ST_PAYLOAD;
                end
            end
            ST_PAYLOAD: begin
                if (!tx_en) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Burst bookkeeping: edge detect, latched length, preamble index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            pre_idx <= '0;
            len_q   <= '0;
        end else begin
            tx_en_q <= tx_en;
            if (rise) begin
                pre_idx <= '0;
                len_q   <= eff_len;
            end else if ((state == ST_PREAMBLE) && tx_en && bit_stb) begin
                pre_idx <= pre_idx + LEN_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        load_seed = rise && (state == ST_IDLE);
        emit      = (state != ST_IDLE) && tx_en && bit_stb;
        advance   = (state == ST_PAYLOAD) && tx_en && bit_stb;
    end

endmodule

// File: rtl/burst_scrambler.sv
module burst_scrambler #(
    parameter int PRE_BITS = 96,
    parameter int SEED_W   = 15,
    parameter int LEN_W    = $clog2(PRE_BITS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_en,
    input  logic                bit_stb,
    input  logic                din,
    input  logic [2:0]          mode,
    input  logic                poly_sel,
    input  logic [SEED_W-1:0]   seed,
    input  logic [LEN_W-1:0]    pre_len,
    input  logic [PRE_BITS-1:0] pre_word,
    output logic                dout,
    output logic                dout_vld,
    output logic                dout_is_pre
);
    import bscr_pkg::*;

    bscr_state_e         state;
    logic [LEN_W-1:0]    eff_len;
    logic [LEN_W-1:0]    pre_idx;
    logic [LEN_W-1:0]    pre_pos;
    logic                load_seed;
    logic                advance;
    logic                emit;
    logic [NUM_POLY-1:0] pn_all;
    logic                pn;

    bscr_len_policy #(
        .PRE_BITS (PRE_BITS),
        .LEN_W    (LEN_W)
    ) u_len (
        .mode    (mode),
        .req_len (pre_len),
        .eff_len (eff_len)
    );

    bscr_ctrl #(
        .LEN_W (LEN_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .bit_stb   (bit_stb),
        .eff_len   (eff_len),
        .state     (state),
        .pre_idx   (pre_idx),
        .load_seed (load_seed),
        .advance   (advance),
        .emit      (emit)
    );

    for (genvar g = 0; g < NUM_POLY; g++) begin : g_pn
        bscr_pn_gen #(
            .LEN (poly_len(g)),
            .TAP (poly_tap(g))
        ) u_pn (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load_seed),
            .advance (advance),
            .seed    (seed[poly_len(g)-1:0]),
            .pn      (pn_all[g])
        );
    end

    assign pn      = pn_all[poly_sel];
    assign pre_pos = LEN_W'(PRE_BITS - 1) - pre_idx;

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout        <= 1'b0;
            dout_vld    <= 1'b0;
            dout_is_pre <= 1'b0;
        end else begin
            dout_vld    <= emit;
            dout_is_pre <= emit && (state == ST_PREAMBLE);
            if (!emit) begin
                dout <= 1'b0;
            end else if (state == ST_PREAMBLE) begin
                dout <= pre_word[pre_pos];
            end else begin
                dout <= din ^ pn;
            end
        end
    end

endmodule

// File: rtl/burst_scrambler_chk.sv
module burst_scrambler_chk #(
    parameter int PRE_BITS = 96
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_en,
    input logic       bit_stb,
    input logic [2:0] mode,
    input logic       dout_vld,
    input logic       dout_is_pre
);
    import bscr_pkg::*;

    logic       seen_data;
    logic [7:0] pre_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            seen_data <= 1'b0;
            pre_cnt   <= '0;
        end else if (dout_vld) begin
            if (dout_is_pre) begin
                pre_cnt <= pre_cnt + 8'd1;
            end else begin
                seen_data <= 1'b1;
            end
        end
    end

    AST_VLD_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |-> $past(bit_stb)); // R9
    AST_VLD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        dout_vld |-> $past(tx_en)); // R8
    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> !dout_vld); // R8
    AST_PRE_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_vld && dout_is_pre) |-> !seen_data); // R2
    AST_PRE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_vld && !dout_is_pre && !seen_data) |-> (pre_cnt >= 8'(min_preamble(mode)))); // R3
    AST_PRE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= 8'(PRE_BITS)); // R2
    AST_PRE_FLAG_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        dout_is_pre |-> dout_vld); // R10

endmodule

bind burst_scrambler burst_scrambler_chk #(.PRE_BITS(PRE_BITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en       (tx_en),
    .bit_stb     (bit_stb),
    .mode        (mode),
    .dout_vld    (dout_vld),
    .dout_is_pre (dout_is_pre)
);

// File: tb/burst_scrambler_bench.sv
module burst_scrambler_bench;

    localparam int PRE_BITS = 96;
    localparam int SEED_W   = 15;
    localparam int LEN_W    = 7;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                tx_en;
    logic                bit_stb;
    logic                din;
    logic [2:0]          mode;
    logic                poly_sel;
    logic [SEED_W-1:0]   seed;
    logic [LEN_W-1:0]    pre_len;
    logic [PRE_BITS-1:0] pre_word;
    logic                dout;
    logic                dout_vld;
    logic                dout_is_pre;

    int vectors = 0;
    int misses  = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #5 clk = ~clk;

    burst_scrambler #(
        .PRE_BITS (PRE_BITS),
        .SEED_W   (SEED_W),
        .LEN_W    (LEN_W)
    ) u_burst_scrambler (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_en       (tx_en),
        .bit_stb     (bit_stb),
        .din         (din),
        .mode        (mode),
        .poly_sel    (poly_sel),
        .seed        (seed),
        .pre_len     (pre_len),
        .pre_word    (pre_word),
        .dout        (dout),
        .dout_vld    (dout_vld),
        .dout_is_pre (dout_is_pre)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int floor_of(input int m);
        if (m == 2) return 2;
        if (m == 3 || m == 4) return 4;
        return 0;
    endfunction

    function automatic logic next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg[17];
    endfunction

    // One clock: drive at the falling edge, sample just after the rising edge
    task automatic step(input logic stb, input logic d);
        @(negedge clk);
        bit_stb = stb;
        din     = d;
        @(posedge clk);
        #1;
    endtask

    // One burst; ndata payload bits, gap idle cycles between strobes
    task automatic run_burst(input int m, input int len, input int ps,
                             input logic [14:0] sd, input int ndata,
                             input int gap, input string dtag);
        logic [14:0] s;
        int eff;
        int mlen;
        int ntap;
        logic p;
        logic d;
        logic exp_bit;
        mode     = 3'(m);
        pre_len  = 7'(len);
        poly_sel = 1'(ps);
        seed     = sd;
        eff  = (len > PRE_BITS) ? PRE_BITS : len;
        if (eff < floor_of(m)) eff = floor_of(m);
        mlen = (ps == 0) ? 15 : 6;
        ntap = (ps == 0) ? 14 : 5;
        s    = sd;
        @(negedge clk);
        tx_en   = 1'b1;
        bit_stb = 1'b0;
        @(posedge clk);
        #1;
        chk(dout_vld == 1'b0, "R8 rise-cycle", int'(dout_vld), 0);
        for (int k = 0; k < eff + ndata; k++) begin
            d = next_rand();
            step(1'b1, d);
            chk(dout_vld == 1'b1, "R9 vld", int'(dout_vld), 1);
            if (k < eff) begin
                exp_bit = pre_word[PRE_BITS-1-k];
                chk(dout == exp_bit, (eff != len) ? "R3 clamped pre" : "R2 pre bit",
                    int'(dout), int'(exp_bit));
                chk(dout_is_pre == 1'b1, "R10 pre flag", int'(dout_is_pre), 1);
            end else begin
                p = s[ntap-1] ^ s[mlen-1];
                s = {s[13:0], p};
                exp_bit = d ^ p;
                chk(dout == exp_bit, (k == eff) ? "R4 first data" : dtag,
                    int'(dout), int'(exp_bit));
                chk(dout_is_pre == 1'b0, "R10 data flag", int'(dout_is_pre), 0);
            end
            for (int gi = 0; gi < gap; gi++) begin
                step(1'b0, next_rand());
                chk(dout_vld == 1'b0, "R9 no strobe", int'(dout_vld), 0);
            end
        end
        @(negedge clk);
        tx_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step(1'b1, next_rand());
            chk(dout_vld == 1'b0, "R8 idle strobe", int'(dout_vld), 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        int lens [8] = '{0, 1, 2, 3, 4, 7, 96, 120};
        int idx;
        rst_n    = 1'b0;
        tx_en    = 1'b0;
        bit_stb  = 1'b0;
        din      = 1'b0;
        mode     = 3'd0;
        poly_sel = 1'b0;
        seed     = 15'h0001;
        pre_len  = '0;
        pre_word = 96'hA5C3_0F96_3C5A_F00F_1234_9ABC;
        repeat (4) @(posedge clk);
        #1;
        chk(dout_vld == 1'b0 && dout == 1'b0 && dout_is_pre == 1'b0, "R1 in reset",
            int'({dout, dout_vld, dout_is_pre}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b1);
        chk(dout_vld == 1'b0 && dout == 1'b0 && dout_is_pre == 1'b0, "R1 after reset",
            int'({dout, dout_vld, dout_is_pre}), 0);

        idx = 0;
        for (int m = 0; m < 5; m++) begin
            for (int li = 0; li < 8; li++) begin
                for (int ps = 0; ps < 2; ps++) begin
                    pre_word = {pre_word[94:0], pre_word[95] ^ pre_word[60]};
                    run_burst(m, lens[li], ps, 15'(idx * 977 + 3), 24, (idx % 2) + 1,
                              (ps == 0) ? "R5 data bit" : "R6 data bit");
                    idx++;
                end
            end
        end

        // Truncated burst then a full burst on the same seed
        for (int ps = 0; ps < 2; ps++) begin
            run_burst(1, 0, ps, 15'h2B4D, 5, 1, "R7 short burst");
            run_burst(1, 0, ps, 15'h2B4D, 40, 1, "R7 seed reload");
            run_burst(7, 2, ps, 15'h7FFF, 30, 2, "R7 seed reload");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule